// File: doc/BRIEF.md
# Serial Adjustment Register Bank

This block is a two-wire serial bus target that holds a bank of byte-wide adjustment and control registers and answers reads with a single status byte. A system clock oversamples both bus lines. Each line goes through a two-flop synchronizer and a counter filter that rejects short pulses, and only then is it edge-detected. The decoder recognises start and stop conditions, checks the device address, loads a register pointer from the subaddress byte and writes the following data bytes. After each written byte the pointer moves up by one, so a long burst can reload the whole bank in one transfer.

A read to the device returns one reply byte assembled from status inputs, with no subaddress phase. A supply-low input forces every register to its default and keeps it there while asserted. The target only ever pulls SDA low through `sda_oe`. The surrounding logic resolves the open-drain line.

Top module: `i2c_adj_bank`

## Requirements
- R1: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 5 clocks, 50 ns at 100 MHz) has no effect on decoding.
- R2: The target acknowledges, by driving SDA low during the ninth clock, only the address bytes 0x8C (write) and 0x8D (read), i.e. bits 7:1 equal DEV_ADDR = 0x46. Any other address is not acknowledged, and the bus is then ignored until the next start.
- R3: In a write, the byte after the address loads the register pointer from its low 5 bits. The next byte is stored at that location and acknowledged.
- R4: Each further data byte in the same transfer is stored at the previous location plus one. Location 31 is followed by location 0.
- R5: In a read, the target sends one byte MSB first: bit0 horizontal lock, bit1 vertical lock, bit2 x-ray latched, bit3 horizontal polarity, bit4 vertical polarity, bit5 horizontal sync present, bit6 vertical sync present, bit7 zero.
- R6: A stop condition returns the decoder to idle with SDA released. Clocks that follow without a new start are neither acknowledged nor stored.
- R7: A repeated start aborts the current transfer and begins a new address phase.
- R8: A byte cut short by a start or stop is discarded and never written.
- R9: While rst_n is low, register i holds its default 0x80 | i, and SDA is released.
- R10: While supply_low is high, every register holds its default, and writes have no effect on the register outputs.
- R11: The target changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| supply_low | input | 1 | Low-supply flag; holds all registers at default |
| h_lock | input | 1 | Horizontal lock status |
| v_lock | input | 1 | Vertical lock status |
| xray | input | 1 | X-ray protection latched flag |
| h_pol | input | 1 | Detected horizontal sync polarity |
| v_pol | input | 1 | Detected vertical sync polarity |
| h_sync | input | 1 | Horizontal sync present |
| v_sync | input | 1 | Vertical sync present |
| regs_o | output | NREGS*8 | Register bank, location i in bits i*8+7 : i*8 |

## Verification
The assertions assume a well-formed bus: the controller never makes a start or stop while the target holds SDA low, and SDA otherwise moves only while SCL is low. They also assume every bus level, apart from deliberate glitches, lasts well over FILT_LEN clocks. The bench master keeps each quarter bit at 40 system clocks and changes data only in the low phase of SCL. It releases SDA during every acknowledge and reply bit. Its only glitches are 4-clock pulses, one clock under the filter length.

// File: rtl/i2c_adj_bank.sv
module i2c_adj_bank #(
  parameter int         NREGS    = 32,
  parameter logic [6:0] DEV_ADDR = 7'h46,
  parameter int         FILT_LEN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               supply_low,
  input  logic               h_lock,
  input  logic               v_lock,
  input  logic               xray,
  input  logic               h_pol,
  input  logic               v_pol,
  input  logic               h_sync,
  input  logic               v_sync,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int PW = $clog2(NREGS);
  localparam int CW = $clog2(FILT_LEN + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_SUB = 3'd2, S_DATA = 3'd3,
                         S_RACK = 3'd4, S_READ = 3'd5, S_SKIP = 3'd6;

  logic [1:0] raw, flt, flt_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic          m1, m2, q;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        m1 <= 1'b1; m2 <= 1'b1; q <= 1'b1; cnt <= '0;
      end else begin
        m1 <= raw[g];
        m2 <= m1;
        if (m2 == q) cnt <= '0;
        else if (cnt == CW'(FILT_LEN - 1)) begin q <= m2; cnt <= '0; end
        else cnt <= cnt + 1'b1;
      end
    assign flt[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flt_q <= 2'b11;
    else        flt_q <= flt;

  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;
  assign scl_f    = flt[1];
  assign sda_f    = flt[0];
  assign scl_rise = scl_f & ~flt_q[1];
  assign scl_fall = ~scl_f & flt_q[1];
  assign start_c  = scl_f & flt_q[1] & flt_q[0] & ~sda_f;
  assign stop_c   = scl_f & flt_q[1] & ~flt_q[0] & sda_f;

  logic [7:0] reply;
  assign reply = {1'b0, v_sync, h_sync, v_pol, h_pol, xray, v_lock, h_lock};

  logic [2:0]    state;
  logic [3:0]    bitcnt;
  logic [7:0]    rxsh;
  logic [6:0]    txsh;
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; rxsh <= '0; txsh <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      state <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (state != S_IDLE && state != S_SKIP) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) rxsh <= {rxsh[6:0], sda_f};
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (state)
            S_ADDR:
              if (rxsh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                state  <= rxsh[0] ? S_RACK : S_SUB;
              end else state <= S_SKIP;
            S_SUB:  begin ptr <= rxsh[PW-1:0]; sda_oe <= 1'b1; state <= S_DATA; end
            S_DATA: begin ptr <= ptr + 1'b1; sda_oe <= 1'b1; end
            S_READ: sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == S_RACK) begin
            txsh <= reply[6:0]; sda_oe <= ~reply[7]; state <= S_READ;
          end else if (state == S_READ) begin
            sda_oe <= 1'b0; state <= S_SKIP;
          end else sda_oe <= 1'b0;
        end else if (state == S_READ && bitcnt != 4'd0) begin
          sda_oe <= ~txsh[6];
          txsh   <= {txsh[5:0], 1'b0};
        end
      end
    end

  logic wr_en;
  assign wr_en = scl_fall && bitcnt == 4'd8 && state == S_DATA && !start_c && !stop_c;

  function automatic logic [7:0] dflt(input int i);
    return 8'h80 | 8'(i);
  endfunction

  logic [7:0] bank [NREGS];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          for (int i = 0; i < NREGS; i++) bank[i] <= dflt(i);
    else if (supply_low) for (int i = 0; i < NREGS; i++) bank[i] <= dflt(i);
    else if (wr_en)      bank[ptr] <= rxsh;

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = bank[g];
  end
endmodule

// File: rtl/i2c_adj_bank_sva.sv
module i2c_adj_bank_sva #(
  parameter int NREGS = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               supply_low,
  input logic               scl_f,
  input logic               scl_fall,
  input logic               start_c,
  input logic               stop_c,
  input logic [2:0]         state,
  input logic [3:0]         bitcnt,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_o
);
  function automatic logic [NREGS*8-1:0] all_dflt();
    logic [NREGS*8-1:0] r;
    for (int i = 0; i < NREGS; i++) r[i*8 +: 8] = 8'h80 + 8'(i);
    return r;
  endfunction

  AST_SUPPLY_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> regs_o == all_dflt()); // R10

  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_fall) && !$past(supply_low)) |-> $stable(regs_o)); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == 3'd0 && !sda_oe)); // R6

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == 3'd1 && bitcnt == 4'd0)); // R7

  AST_ACK_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state != 3'd5) |-> bitcnt == 4'd8); // R2

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_f); // R11
endmodule

bind i2c_adj_bank i2c_adj_bank_sva #(.NREGS(NREGS)) u_sva (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .scl_f(scl_f),
  .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c), .state(state),
  .bitcnt(bitcnt), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/test_i2c_adj_bank.sv
module test_i2c_adj_bank;
  localparam int Q = 40;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, supply_low = 1'b0;
  logic [6:0] st = '0;
  logic sda_oe;
  logic [255:0] regs_o;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_adj_bank i_i2c_adj_bank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .supply_low(supply_low), .h_lock(st[0]), .v_lock(st[1]), .xray(st[2]),
    .h_pol(st[3]), .v_pol(st[4]), .h_sync(st[5]), .v_sync(st[6]), .regs_o(regs_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mirror [32];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_mirror();
    for (int i = 0; i < 32; i++) mirror[i] = 8'h80 | 8'(i);
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 32; i++) chk(req, regs_o[i*8 +: 8], mirror[i]);
  endtask

  task automatic put_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 7) begin tick(Q/2); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(Q/2); end
      else tick(Q);
      scl_m = 1'b1;
      if (glitch && i == 7) begin tick(Q); sda_m = 1'b0; tick(4); sda_m = 1'b1; tick(Q-4); end
      else tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic get_byte(output logic [7:0] b, input logic nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic wr(input string req, input logic [7:0] b);
    logic a;
    put_byte(b, 1'b0, a);
    chk(req, {7'd0, a}, 8'd1);
  endtask

  task automatic t_reset();
    chk("R9 sda released", {7'd0, sda_oe}, 8'd0);
    chk_bank("R9 defaults");
  endtask

  task automatic t_single_write();
    put_start(); wr("R2 write addr ack", 8'h8C); wr("R3 sub ack", 8'h03);
    wr("R3 data ack", 8'h5A); put_stop();
    mirror[3] = 8'h5A;
    chk_bank("R3 single write");
  endtask

  task automatic t_burst_wrap();
    put_start(); wr("R2", 8'h8C); wr("R3", 8'h1E);
    for (int i = 0; i < 4; i++) begin
      wr("R4 burst ack", 8'hA0 + 8'(i));
      mirror[(30 + i) % 32] = 8'hA0 + 8'(i);
    end
    put_stop();
    chk_bank("R4 auto-increment wrap");
  endtask

  task automatic t_wrong_addr();
    logic a;
    put_start();
    put_byte(8'h90, 1'b0, a); chk("R2 no ack foreign addr", {7'd0, a}, 8'd0);
    put_byte(8'h03, 1'b0, a); chk("R2 ignored after mismatch", {7'd0, a}, 8'd0);
    put_byte(8'hEE, 1'b0, a); chk("R2 ignored after mismatch", {7'd0, a}, 8'd0);
    put_stop();
    chk_bank("R2 no write on mismatch");
  endtask

  task automatic t_read(input logic [6:0] pat);
    logic [7:0] b;
    st = pat;
    put_start(); wr("R2 read addr ack", 8'h8D);
    get_byte(b, 1'b1);
    put_stop();
    chk("R5 reply byte", b, {1'b0, pat});
    chk("R6 released after read", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_partial();
    put_start(); wr("R8", 8'h8C); wr("R8", 8'h05);
    put_bits(8'hF0, 4);
    put_stop();
    chk_bank("R8 partial byte dropped");
  endtask

  task automatic t_stop_idle();
    logic a;
    put_start(); wr("R6", 8'h8C); wr("R6", 8'h07); wr("R6", 8'h77); put_stop();
    mirror[7] = 8'h77;
    scl_m = 1'b0; tick(Q);
    put_byte(8'h8C, 1'b0, a); chk("R6 no ack without start", {7'd0, a}, 8'd0);
    put_byte(8'h07, 1'b0, a); chk("R6 no ack without start", {7'd0, a}, 8'd0);
    put_byte(8'h99, 1'b0, a); chk("R6 no ack without start", {7'd0, a}, 8'd0);
    scl_m = 1'b1; tick(Q);
    chk_bank("R6 idle after stop");
  endtask

  task automatic t_restart();
    put_start(); wr("R7", 8'h8C); wr("R7", 8'h0A); wr("R7", 8'h11);
    put_start(); wr("R7 addr after restart", 8'h8C); wr("R7", 8'h0C); wr("R7", 8'h22);
    put_stop();
    mirror[10] = 8'h11; mirror[12] = 8'h22;
    chk_bank("R7 repeated start");
  endtask

  task automatic t_glitch();
    logic a;
    put_start(); wr("R1", 8'h8C); wr("R1", 8'h14);
    put_byte(8'hC3, 1'b1, a); chk("R1 ack with glitches", {7'd0, a}, 8'd1);
    put_stop();
    mirror[20] = 8'hC3;
    chk_bank("R1 glitch rejected");
  endtask

  task automatic t_supply();
    put_start(); wr("R10", 8'h8C); wr("R10", 8'h02); wr("R10", 8'h12); put_stop();
    mirror[2] = 8'h12;
    chk("R10 before low", regs_o[2*8 +: 8], 8'h12);
    supply_low = 1'b1; tick(5);
    reset_mirror();
    chk_bank("R10 forced defaults");
    put_start(); wr("R10", 8'h8C); wr("R10", 8'h04); wr("R10", 8'h44); put_stop();
    chk("R10 write blocked", regs_o[4*8 +: 8], 8'h84);
    supply_low = 1'b0; tick(5);
    chk_bank("R10 defaults kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    reset_mirror();
    tick(10);
    t_reset();
    rst_n = 1'b1; tick(10);
    t_single_write();
    t_burst_wrap();
    t_wrong_addr();
    t_read(7'b1010101);
    t_read(7'b0101010);
    t_read(7'h7F);
    t_partial();
    t_stop_idle();
    t_restart();
    t_glitch();
    t_supply();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule